// File: doc/BRIEF.md
# LIN Master Frame Transmitter

This block is the send half of a LIN bus master that sits on top of an 8N1 serial character format. A one-cycle start request launches a frame. The block first holds the line dominant (low) for a break of 13 to 16 bit times, selected by a two-bit code. It then releases the line for one recessive delimiter bit. After that it reads bytes from a show-ahead FIFO and sends them back to back until the FIFO runs dry. Software places the bytes in the FIFO in this order: the 0x55 sync byte, the identifier, the data bytes and the checksum.

The bit period and the break code are captured when the frame starts, so the inputs may change while a frame is running. The block does not compute the checksum or the identifier parity, and it does not watch the bus.

Top module: `lin_hdr_tx`

## Requirements
- R1: Outside a frame, `tx_o` is 1, `busy_o` is 0 and `done_o` is 0, including right after reset.
- R2: A `start_i` pulse that is seen while idle makes `tx_o` go to 0 and `busy_o` go to 1 in the next cycle.
- R3: The break lasts (13 + `brk_len_i`) bit periods. `brk_len_i` is the two-bit code 0..3 and is captured at start.
- R4: One bit period is `bit_div_i` + 1 clock cycles. This value is captured at start and applies to every bit of the frame.
- R5: Exactly one bit period of `tx_o` = 1 follows the break, before the first start bit.
- R6: Each byte goes out as one start bit (0), then eight data bits with the least significant bit first, then one stop bit (1).
- R7: Bytes leave in FIFO order with no gap between them. Each byte is taken by a single-cycle `fifo_rd_o`, and `fifo_data_i` is sampled in that same cycle.
- R8: If the FIFO is empty when the delimiter or a stop bit ends, the frame ends. In the following cycle `done_o` is 1 for exactly one cycle, `busy_o` is 0 and `tx_o` is 1.
- R9: A `start_i` pulse, or a change of `brk_len_i` or `bit_div_i`, during a frame does not alter that frame.
- R10: `fifo_rd_o` is never asserted while `fifo_empty_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Frame start request (one cycle) |
| brk_len_i | input | 2 | Break code; break is 13 + code bit times |
| bit_div_i | input | DIV_W | Bit period minus one, in clock cycles |
| fifo_empty_i | input | 1 | FIFO holds no byte |
| fifo_data_i | input | DATA_W | Head-of-FIFO byte (show-ahead) |
| fifo_rd_o | output | 1 | Pop the head byte |
| tx_o | output | 1 | Serial line, idle high |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse at frame end |

## Verification
A break counter that stops one bit early or late makes the first rising edge of `tx_o` arrive one full bit period off. The per-cycle comparison catches this in the first cycle of the error. A wrong bit index or a wrong shifter fill corrupts a data or stop bit, and that bit is wrong on `tx_o` for its whole bit period. A missing or extra pop leaves bytes in the FIFO, or sends a wrong byte, and the mismatch shows within one character time. An end-of-frame decision in the wrong state shows up as `done_o` or `busy_o` disagreeing with the model on the cycle it happens.

// File: rtl/lin_tx_pkg.sv
package lin_tx_pkg;
  localparam int BRK_MIN = 13;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_BRK   = 2'd1,
    S_DELIM = 2'd2,
    S_CHAR  = 2'd3
  } lin_st_e;
endpackage

// File: rtl/lin_bit_timer.sv
module lin_bit_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt;

  assign tick_o = (cnt == div_i);

  always_ff @(posedge clk) begin
    if (rst || restart_i) cnt <= '0;
    else if (tick_o)      cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    !restart_i |=> (cnt <= div_i)); // R4
endmodule

// File: rtl/lin_char_shifter.sv
module lin_char_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              shift_i,
  output logic              bit_o
);
  logic [DATA_W:0] sh;

  assign bit_o = sh[0];

  always_ff @(posedge clk) begin
    if (rst)          sh <= '1;
    else if (load_i)  sh <= {1'b1, data_i};
    else if (shift_i) sh <= {1'b1, sh[DATA_W:1]};
  end

  AST_STOP_FILL: assert property (@(posedge clk) disable iff (rst)
    load_i |=> sh[DATA_W]); // R6
endmodule

// File: rtl/lin_hdr_tx.sv
module lin_hdr_tx
  import lin_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [1:0]        brk_len_i,
  input  logic [DIV_W-1:0]  bit_div_i,
  input  logic              fifo_empty_i,
  input  logic [DATA_W-1:0] fifo_data_i,
  output logic              fifo_rd_o,
  output logic              tx_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int CHAR_LAST = DATA_W + 1;
  localparam int MAXB      = (BRK_MIN + 3 > CHAR_LAST) ? BRK_MIN + 3 : CHAR_LAST;
  localparam int BCNT_W    = $clog2(MAXB + 1);

  lin_st_e           st;
  logic [BCNT_W-1:0] bitn;
  logic [1:0]        brk_q;
  logic [DIV_W-1:0]  div_q;
  logic              tx_q, busy_q, done_q;
  logic              tick, accept, boundary, load, shift, sh_bit;
  logic [BCNT_W-1:0] brk_last;

  assign accept   = (st == S_IDLE) && start_i;
  assign brk_last = BCNT_W'(BRK_MIN - 1) + BCNT_W'(brk_q);
  assign boundary = tick && ((st == S_DELIM) ||
                    ((st == S_CHAR) && (bitn == BCNT_W'(CHAR_LAST))));
  assign load     = boundary && !fifo_empty_i;
  assign shift    = tick && (st == S_CHAR) && (bitn != BCNT_W'(CHAR_LAST));

  lin_bit_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst(rst), .restart_i(accept), .div_i(div_q), .tick_o(tick)
  );

  lin_char_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .load_i(load), .data_i(fifo_data_i),
    .shift_i(shift), .bit_o(sh_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      bitn   <= '0;
      brk_q  <= '0;
      div_q  <= '0;
      tx_q   <= 1'b1;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start_i) begin
            st     <= S_BRK;
            tx_q   <= 1'b0;
            busy_q <= 1'b1;
            bitn   <= '0;
            brk_q  <= brk_len_i;
            div_q  <= bit_div_i;
          end
        end
        S_BRK: begin
          if (tick) begin
            if (bitn == brk_last) begin
              st   <= S_DELIM;
              tx_q <= 1'b1;
            end else begin
              bitn <= bitn + 1'b1;
            end
          end
        end
        S_DELIM, S_CHAR: begin
          if (boundary) begin
            if (!fifo_empty_i) begin
              st   <= S_CHAR;
              tx_q <= 1'b0;
              bitn <= '0;
            end else begin
              st     <= S_IDLE;
              tx_q   <= 1'b1;
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end
          end else if (shift) begin
            tx_q <= sh_bit;
            bitn <= bitn + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign fifo_rd_o = load;
  assign tx_o      = tx_q;
  assign busy_o    = busy_q;
  assign done_o    = done_q;

  AST_RD_ONLY_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    fifo_rd_o |-> !fifo_empty_i); // R10
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R8
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o))); // R8
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> tx_o); // R1
  AST_START_DRIVES_BREAK: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> (busy_o && !tx_o)); // R2
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (start_i && busy_o) |=> ($stable(brk_q) && $stable(div_q))); // R9
endmodule

// File: tb/sim_lin_hdr_tx.sv
module sim_lin_hdr_tx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [1:0] brk_len_i = 2'd0;
  logic [15:0] bit_div_i = 16'd0;
  logic       fifo_empty_i = 1'b1;
  logic [7:0] fifo_data_i = 8'd0;
  logic       fifo_rd_o, tx_o, busy_o, done_o;

  int checks = 0;
  int fails  = 0;
  int pops   = 0;
  bit chk_on = 1'b0;
  bit fin    = 1'b0;
  bit rd_seen = 1'b0;
  string ph_tag = "R1";

  logic [7:0] fq[$];
  logic [7:0] load_q[$];
  bit    e_tx[$];
  bit    e_busy[$];
  bit    e_done[$];
  string e_tag[$];

  always #4 clk = ~clk;

  lin_hdr_tx u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .brk_len_i(brk_len_i),
    .bit_div_i(bit_div_i), .fifo_empty_i(fifo_empty_i), .fifo_data_i(fifo_data_i),
    .fifo_rd_o(fifo_rd_o), .tx_o(tx_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic sync_fifo();
    fifo_empty_i = (fq.size() == 0);
    fifo_data_i  = (fq.size() != 0) ? fq[0] : 8'h00;
  endtask

  task automatic push_exp(input bit t, input bit b, input bit d, input string tg, input int n);
    for (int i = 0; i < n; i++) begin
      e_tx.push_back(t); e_busy.push_back(b); e_done.push_back(d); e_tag.push_back(tg);
    end
  endtask

  task automatic check(input bit ok, input string tg, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tg, act, exp);
    end
  endtask

  // per-cycle comparison against the reference model
  always @(negedge clk) begin
    rd_seen = fifo_rd_o;
    if (chk_on) begin
      bit t, b, d; string tg;
      if (e_tx.size() > 0) begin
        t = e_tx.pop_front(); b = e_busy.pop_front(); d = e_done.pop_front(); tg = e_tag.pop_front();
      end else begin
        t = 1'b1; b = 1'b0; d = 1'b0; tg = "R1";
      end
      checks++;
      if (tx_o !== t || busy_o !== b || done_o !== d) begin
        fails++;
        $display("FAIL %s (%s): tx/busy/done actual %b%b%b expected %b%b%b",
                 tg, ph_tag, tx_o, busy_o, done_o, t, b, d);
      end
    end
  end

  // FIFO model: pop after the edge that consumed the head
  always @(posedge clk) begin
    #1;
    if (rd_seen && fq.size() > 0) begin
      void'(fq.pop_front());
      pops++;
      sync_fifo();
    end
  end

  // run one frame: b = break code, d = divider; bytes come from load_q
  task automatic run_frame(input int b, input int d, input bit poke_busy);
    int nb, per;
    @(posedge clk); #2;
    fq = load_q; pops = 0; nb = load_q.size(); sync_fifo();
    brk_len_i = 2'(b); bit_div_i = 16'(d); start_i = 1'b1;
    @(posedge clk); #2;
    start_i = 1'b0;
    per = d + 1;
    push_exp(1'b0, 1'b1, 1'b0, "R2", per);
    push_exp(1'b0, 1'b1, 1'b0, "R3", (12 + b) * per);
    push_exp(1'b1, 1'b1, 1'b0, "R5", per);
    foreach (load_q[k]) begin
      push_exp(1'b0, 1'b1, 1'b0, "R6", per);
      for (int j = 0; j < 8; j++) push_exp(load_q[k][j], 1'b1, 1'b0, "R7", per);
      push_exp(1'b1, 1'b1, 1'b0, "R6", per);
    end
    push_exp(1'b1, 1'b0, 1'b1, "R8", 1);
    if (poke_busy) begin
      // R9: mid-frame start and input changes must not disturb the frame
      repeat (3 * per) @(posedge clk);
      #2; start_i = 1'b1; brk_len_i = 2'(3 - b); bit_div_i = 16'(d + 2);
      @(posedge clk); #2; start_i = 1'b0;
    end
    while (e_tx.size() > 0) @(posedge clk);
    repeat (3) @(posedge clk);
    #2;
    check(fq.size() == 0, "R7 fifo drained", fq.size(), 0);
    check(pops == nb, "R7 pop count", pops, nb);
  endtask

  initial begin
    #(200000 * 8);
    if (!fin) begin
      checks++; fails++;
      $display("FAIL R1: watchdog expired, actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    chk_on = 1'b1;
    ph_tag = "R1";
    repeat (4) @(posedge clk);   // idle after reset compared each cycle (R1)

    ph_tag = "R4";               // divider 1: two cycles per bit
    load_q = '{8'h55, 8'hA3, 8'h01, 8'hFE, 8'h5C};
    run_frame(0, 1, 1'b0);

    ph_tag = "R3";               // longest break, three cycles per bit
    load_q = '{8'h55, 8'h3C, 8'h80};
    run_frame(3, 2, 1'b0);

    ph_tag = "R4";               // divider 0: one cycle per bit
    load_q = '{8'h55, 8'h00, 8'hFF};
    run_frame(1, 0, 1'b0);

    ph_tag = "R9";
    load_q = '{8'h55, 8'h96, 8'h42};
    run_frame(2, 1, 1'b1);

    ph_tag = "R8";               // empty FIFO: break and delimiter only
    load_q = {};
    run_frame(0, 1, 1'b0);

    ph_tag = "R1";
    repeat (5) @(posedge clk);
    fin = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule